// File: doc/BRIEF.md
# Write-Intensity Predictor Table

This block keeps a small, fully associative table that connects store-instruction program counters to the number of times their data was written back to memory. The cache controller sends one event per dirty writeback. Each event carries the program counter of the store that produced the line. A PC that is already in the table has its counter incremented. A PC that is not in the table replaces the least recently updated entry and starts with a count of one.

A lookup port accepts a PC and answers one cycle later. The answer says whether the PC is present, gives its writeback count, and says whether that count reaches a programmable threshold. When the lookup is marked as the first touch of a page, the block also produces a page-allocation decision. A write-intensive instruction gets a fast-write page. Any other instruction gets a fast-read page. A PC that is not in the table is never treated as write-intensive.

Top module: `wip_table`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every response and allocation output is 0, and the table holds no entries, so any later lookup misses until the first update arrives.
- R2: `resp_valid` is high exactly in the cycle after a cycle with `qry_valid` high.
- R3: An update whose PC is absent stores that PC in an entry with a count of 1.
- R4: An update whose PC is present increments that entry's count by 1.
- R5: Counts saturate at 2^CNT_W-1. Further updates leave the count at that value.
- R6: On a lookup hit, `resp_wi` is 1 exactly when the stored count is greater than or equal to the `wi_thresh` value presented with the lookup.
- R7: On a lookup miss, `resp_hit`, `resp_wi` and `resp_count` are all 0, whatever the threshold is, including a threshold of 0.
- R8: When an update and a lookup arrive in the same cycle, both are served, and the lookup returns the table contents from before that update.
- R9: When a new PC arrives and the table is full, the entry that was updated least recently is replaced. Lookups do not change the replacement order. A PC is never held in two entries.
- R10: `alloc_valid` is high in the cycle after a lookup with `qry_first_touch` high. In that cycle, `alloc_fast_write` is 1 (fast-write page) when the lookup was write-intensive and 0 (fast-read page) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Writeback event strobe from the cache controller |
| upd_pc | input | PC_W | PC of the store whose data was written back |
| qry_valid | input | 1 | Lookup strobe |
| qry_pc | input | PC_W | PC to look up |
| qry_first_touch | input | 1 | The lookup is for the first touch of a page |
| wi_thresh | input | CNT_W | Count at or above which a PC is write-intensive |
| resp_valid | output | 1 | Lookup answer valid |
| resp_hit | output | 1 | PC was present |
| resp_wi | output | 1 | PC is write-intensive |
| resp_count | output | CNT_W | Stored writeback count (0 on a miss) |
| alloc_valid | output | 1 | Page-allocation decision valid |
| alloc_fast_write | output | 1 | 1 selects a fast-write page, 0 a fast-read page |

## Verification
The bench builds the table with 4 entries, 3-bit counters and 16-bit PCs. With 4 entries, replacement of the oldest entry is reached after only a few distinct PCs. With 3-bit counters, saturation at 7 is reached after a handful of writebacks. The eviction sequence includes a lookup of the oldest PC just before it is replaced, which shows that lookups do not refresh recency. Threshold values of 0, 1, 3 and 7 test the hit and miss rules at their edges.

// File: rtl/wip_pkg.sv
package wip_pkg;
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wip_match.sv
module wip_match #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PC_W    = 32,
  localparam int unsigned IW     = wip_pkg::idx_bits(ENTRIES)
) (
  input  logic [PC_W-1:0] tags [ENTRIES],
  input  logic [ENTRIES-1:0] valid,
  input  logic [PC_W-1:0] key,
  output logic [ENTRIES-1:0] hit_vec,
  output logic            hit,
  output logic [IW-1:0]   hit_idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = IW'(i);
  end
endmodule

// File: rtl/wip_lru.sv
module wip_lru #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IW     = wip_pkg::idx_bits(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  logic [IW-1:0] age [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst)
        age[g] <= IW'(g);
      else if (touch) begin
        if (touch_idx == IW'(g))
          age[g] <= '0;
        else if (age[g] < age[touch_idx])
          age[g] <= age[g] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age[i] == IW'(ENTRIES - 1)) victim_idx = IW'(i);
  end
endmodule

// File: rtl/wip_table.sv
module wip_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             qry_valid,
  input  logic [PC_W-1:0]  qry_pc,
  input  logic             qry_first_touch,
  input  logic [CNT_W-1:0] wi_thresh,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_wi,
  output logic [CNT_W-1:0] resp_count,
  output logic             alloc_valid,
  output logic             alloc_fast_write
);
  localparam int unsigned IW = wip_pkg::idx_bits(ENTRIES);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PC_W-1:0]    tag_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  logic [ENTRIES-1:0] upd_hit_vec, qry_hit_vec;
  logic               upd_hit, qry_hit;
  logic [IW-1:0]      upd_idx, qry_idx, victim_idx, touch_idx;

  wip_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_upd_match (
    .tags(tag_q), .valid(valid_q), .key(upd_pc),
    .hit_vec(upd_hit_vec), .hit(upd_hit), .hit_idx(upd_idx)
  );

  wip_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_qry_match (
    .tags(tag_q), .valid(valid_q), .key(qry_pc),
    .hit_vec(qry_hit_vec), .hit(qry_hit), .hit_idx(qry_idx)
  );

  assign touch_idx = upd_hit ? upd_idx : victim_idx;

  wip_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch(upd_valid),
    .touch_idx(touch_idx), .victim_idx(victim_idx)
  );

  // entry payload: no reset, single write port per cycle
  always_ff @(posedge clk) begin
    if (upd_valid) begin
      if (upd_hit) begin
        if (cnt_q[upd_idx] != CNT_MAX)
          cnt_q[upd_idx] <= cnt_q[upd_idx] + 1'b1;
      end else begin
        tag_q[victim_idx] <= upd_pc;
        cnt_q[victim_idx] <= CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      valid_q <= '0;
    else if (upd_valid && !upd_hit)
      valid_q[victim_idx] <= 1'b1;
  end

  // lookup reads pre-update state, answer registered
  logic [CNT_W-1:0] qry_cnt;
  logic             qry_wi;
  assign qry_cnt = qry_hit ? cnt_q[qry_idx] : '0;
  assign qry_wi  = qry_hit && (qry_cnt >= wi_thresh);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid       <= 1'b0;
      resp_hit         <= 1'b0;
      resp_wi          <= 1'b0;
      resp_count       <= '0;
      alloc_valid      <= 1'b0;
      alloc_fast_write <= 1'b0;
    end else begin
      resp_valid       <= qry_valid;
      resp_hit         <= qry_valid && qry_hit;
      resp_wi          <= qry_valid && qry_wi;
      resp_count       <= qry_valid ? qry_cnt : '0;
      alloc_valid      <= qry_valid && qry_first_touch;
      alloc_fast_write <= qry_valid && qry_first_touch && qry_wi;
    end
  end
endmodule

// File: rtl/wip_table_chk.sv
module wip_table_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned CNT_W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             qry_valid,
  input logic             qry_first_touch,
  input logic [CNT_W-1:0] wi_thresh,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic             resp_wi,
  input logic [CNT_W-1:0] resp_count,
  input logic             alloc_valid,
  input logic             alloc_fast_write,
  input logic [ENTRIES-1:0] upd_hit_vec,
  input logic [ENTRIES-1:0] qry_hit_vec
);
  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    qry_valid |=> resp_valid);
  assert_resp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !qry_valid |=> !resp_valid);
  assert_miss_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> (!resp_wi && resp_count == '0));
  assert_hit_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    resp_hit |-> resp_count != '0);
  assert_wi_thresh_R6: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> (resp_wi == (resp_count >= $past(wi_thresh))));
  assert_alloc_R10: assert property (@(posedge clk) disable iff (rst)
    (qry_valid && qry_first_touch) |=> (alloc_valid && alloc_fast_write == resp_wi));
  assert_unique_tag_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(upd_hit_vec) && $onehot0(qry_hit_vec));
endmodule

bind wip_table wip_table_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .qry_valid(qry_valid), .qry_first_touch(qry_first_touch),
  .wi_thresh(wi_thresh), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .resp_wi(resp_wi), .resp_count(resp_count), .alloc_valid(alloc_valid),
  .alloc_fast_write(alloc_fast_write), .upd_hit_vec(upd_hit_vec),
  .qry_hit_vec(qry_hit_vec)
);

// File: tb/tb_wip_table.sv
`timescale 1ns/100ps
module tb_wip_table;
  localparam int unsigned ENTRIES = 4;
  localparam int unsigned PC_W    = 16;
  localparam int unsigned CNT_W   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_valid = 1'b0, qry_valid = 1'b0, qry_first_touch = 1'b0;
  logic [PC_W-1:0] upd_pc = '0, qry_pc = '0;
  logic [CNT_W-1:0] wi_thresh = '0;
  logic resp_valid, resp_hit, resp_wi, alloc_valid, alloc_fast_write;
  logic [CNT_W-1:0] resp_count;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  wip_table #(.ENTRIES(ENTRIES), .PC_W(PC_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .qry_valid(qry_valid), .qry_pc(qry_pc), .qry_first_touch(qry_first_touch),
    .wi_thresh(wi_thresh), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_wi(resp_wi), .resp_count(resp_count), .alloc_valid(alloc_valid),
    .alloc_fast_write(alloc_fast_write)
  );

  typedef struct packed {
    logic             uv;
    logic [PC_W-1:0]  upc;
    logic             qv;
    logic [PC_W-1:0]  qpc;
    logic             ft;
    logic [CNT_W-1:0] th;
    logic             eh;
    logic             ew;
    logic [CNT_W-1:0] ec;
  } vec_t;

  localparam logic [PC_W-1:0] PA = 16'h0010, PB = 16'h0020, PC = 16'h0030,
                              PD = 16'h0040, PE = 16'h0050;

  // R3 R4 R6 R7 R8 R9 R10 scenario
  localparam vec_t VEC [14] = '{
    '{1'b1, PA, 1'b1, PA, 1'b0, 3'd3, 1'b0, 1'b0, 3'd0},
    '{1'b1, PA, 1'b1, PA, 1'b0, 3'd3, 1'b1, 1'b0, 3'd1},
    '{1'b1, PA, 1'b1, PA, 1'b0, 3'd3, 1'b1, 1'b0, 3'd2},
    '{1'b0, PA, 1'b1, PA, 1'b1, 3'd3, 1'b1, 1'b1, 3'd3},
    '{1'b1, PB, 1'b1, PB, 1'b1, 3'd3, 1'b0, 1'b0, 3'd0},
    '{1'b1, PC, 1'b1, PB, 1'b0, 3'd3, 1'b1, 1'b0, 3'd1},
    '{1'b1, PD, 1'b1, PC, 1'b0, 3'd3, 1'b1, 1'b0, 3'd1},
    '{1'b1, PE, 1'b1, PA, 1'b0, 3'd3, 1'b1, 1'b1, 3'd3},
    '{1'b0, PA, 1'b1, PA, 1'b1, 3'd0, 1'b0, 1'b0, 3'd0},
    '{1'b0, PA, 1'b1, PE, 1'b0, 3'd3, 1'b1, 1'b0, 3'd1},
    '{1'b1, PB, 1'b1, PD, 1'b0, 3'd1, 1'b1, 1'b1, 3'd1},
    '{1'b1, PA, 1'b1, PC, 1'b0, 3'd3, 1'b1, 1'b0, 3'd1},
    '{1'b0, PA, 1'b1, PC, 1'b0, 3'd3, 1'b0, 1'b0, 3'd0},
    '{1'b0, PA, 1'b1, PA, 1'b0, 3'd3, 1'b1, 1'b0, 3'd1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic uv, input logic [PC_W-1:0] upc,
                      input logic qv, input logic [PC_W-1:0] qpc,
                      input logic ft, input logic [CNT_W-1:0] th);
    @(negedge clk);
    upd_valid = uv; upd_pc = upc; qry_valid = qv; qry_pc = qpc;
    qry_first_touch = ft; wi_thresh = th;
    @(posedge clk);
    #1;
    upd_valid = 1'b0; qry_valid = 1'b0; qry_first_touch = 1'b0;
  endtask

  task automatic chk_resp(input string req, input logic eh, input logic ew,
                          input logic [CNT_W-1:0] ec, input logic ft);
    chk(req, "resp_valid", int'(resp_valid), 1);
    chk(req, "resp_hit", int'(resp_hit), int'(eh));
    chk(req, "resp_wi", int'(resp_wi), int'(ew));
    chk(req, "resp_count", int'(resp_count), int'(ec));
    chk("R10", "alloc_valid", int'(alloc_valid), int'(ft));
    chk("R10", "alloc_fast_write", int'(alloc_fast_write), int'(ft & ew));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet under reset
    chk("R1", "resp_valid in reset", int'(resp_valid), 0);
    chk("R1", "alloc_valid in reset", int'(alloc_valid), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    // R2: no lookup, no answer
    chk("R2", "resp_valid idle", int'(resp_valid), 0);

    for (int i = 0; i < 14; i++) begin
      step(VEC[i].uv, VEC[i].upc, VEC[i].qv, VEC[i].qpc, VEC[i].ft, VEC[i].th);
      chk_resp($sformatf("R8/R9 vec%0d", i), VEC[i].eh, VEC[i].ew, VEC[i].ec, VEC[i].ft);
    end

    // R2: answer lasts one cycle only
    @(posedge clk); #1;
    chk("R2", "resp_valid drops", int'(resp_valid), 0);

    // R5: B holds 2; six more writebacks reach 7 and stay there
    for (int k = 0; k < 6; k++) step(1'b1, PB, 1'b0, '0, 1'b0, 3'd0);
    step(1'b0, '0, 1'b1, PB, 1'b1, 3'd7);
    chk_resp("R5 saturate", 1'b1, 1'b1, 3'd7, 1'b1);
    step(1'b1, PB, 1'b1, PB, 1'b0, 3'd7);
    step(1'b0, '0, 1'b1, PB, 1'b0, 3'd7);
    chk_resp("R5 hold", 1'b1, 1'b1, 3'd7, 1'b0);

    // R6: same count below a raised threshold is not write-intensive
    step(1'b0, '0, 1'b1, PE, 1'b1, 3'd2);
    chk_resp("R6 below", 1'b1, 1'b0, 3'd1, 1'b1);

    // R1: reset empties the table
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", "resp_valid after reset", int'(resp_valid), 0);
    @(negedge clk); rst = 1'b0;
    step(1'b0, '0, 1'b1, PB, 1'b0, 3'd0);
    chk_resp("R1 table empty", 1'b0, 1'b0, 3'd0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule